// File: doc/BRIEF.md
# Synchronous residual timestamp generator

This block produces the 4-bit residual timestamp nibbles that a constant-bit-rate segmentation engine places in its cell headers. A local service clock, taken from one of three sources and presented as a single-cycle enable strobe, is counted down to one terminal pulse per timestamp period. A period covers eight cells of 47 payload bytes, 3008 service-clock ticks, or 3000 ticks in the alternate mode.

On every terminal pulse the current value of one of two free-running 4-bit network-derived counters is sampled and queued in a five-entry nibble FIFO. The segmentation side pops one nibble for each 8-cell sequence it sends. A write to a full queue and a read from an empty queue are each recorded in a sticky flag that stays set until a write-one-to-clear strobe removes it.

Top module: `srts_gen`

## Requirements
- R1: A synchronous active-high reset `rst` empties the FIFO, zeroes the divider count, clears both flags and sets `ts_nibble` to 0.
- R2: With `div_alt` = 0 the divider gives a terminal pulse on the 3008th counted service tick and then starts again from zero, so one sample is queued per 3008 ticks.
- R3: With `div_alt` = 1 the divider gives a terminal pulse on every 3000th counted service tick.
- R4: The value queued is the value of `net_cnt_a` (when `cnt_sel` = 0) or `net_cnt_b` (when `cnt_sel` = 1) in the same cycle as the terminal tick.
- R5: `src_sel` picks the counted tick: 0 = `line_tick`, 1 = `pll_tick`, 2 = `bp_tick`, 3 = none. The unselected strobes have no effect. `bp_tick` counts only while `structured` = 1; with `structured` = 0 source 2 counts nothing.
- R6: The FIFO holds up to five nibbles and returns them in the order they were written.
- R7: A sample that arrives while the FIFO holds five entries, with no pop in that cycle, is dropped and sets `ovf_flag`, which then stays set.
- R8: A pop while the FIFO is empty sets `unf_flag` and leaves `ts_nibble` at the last nibble delivered.
- R9: A one on `clr_ovf` or `clr_unf` clears the matching flag on the next edge. A new event in the same cycle takes precedence over the clear.
- R10: A pop on `ts_pop` at an edge places the oldest nibble on `ts_nibble` at that same edge, where it stays until the next successful pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Service clock source: 0 line, 1 PLL, 2 backplane, 3 none |
| structured | input | 1 | 1 = structured mode; enables the backplane source |
| line_tick | input | 1 | Line input clock enable strobe |
| pll_tick | input | 1 | PLL output clock enable strobe |
| bp_tick | input | 1 | Backplane clock enable strobe |
| div_alt | input | 1 | 1 = period of 3000 ticks, 0 = 3008 ticks |
| cnt_sel | input | 1 | Network counter to sample: 0 = A, 1 = B |
| net_cnt_a | input | 4 | Network-derived counter A |
| net_cnt_b | input | 4 | Network-derived counter B |
| ts_pop | input | 1 | Pop one nibble (once per 8-cell sequence) |
| ts_nibble | output | 4 | Most recently popped timestamp nibble |
| clr_ovf | input | 1 | Write-one-to-clear for `ovf_flag` |
| clr_unf | input | 1 | Write-one-to-clear for `unf_flag` |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underrun flag |

## Verification
A divider that is off by one tick shows as a queued nibble carrying the counter value from before the last tick instead of the one at it. The bench changes the counter value on exactly the final tick of each period so that the first pop after that period exposes the error. A wrong FIFO count or pointer shows within five pops, either as nibbles out of order, as an overflow flag that rises too early or too late, or as an underrun that does not appear when it should. Source-select faults show as nibbles that appear, or fail to appear, after a full period of strobes on a source that should be ignored.

// File: rtl/srts_pkg.sv
package srts_pkg;
   typedef enum logic [1:0] {
      SRC_LINE = 2'b00,
      SRC_PLL  = 2'b01,
      SRC_BP   = 2'b10,
      SRC_NONE = 2'b11
   } src_e;
endpackage

// File: rtl/srts_clk_sel.sv
module srts_clk_sel #(
   parameter bit ALLOW_BP = 1'b1
) (
   input  logic [1:0] src_sel,
   input  logic       structured,
   input  logic       line_tick,
   input  logic       pll_tick,
   input  logic       bp_tick,
   output logic       svc_tick
);
   import srts_pkg::*;

   logic bp_gated;

   generate
      if (ALLOW_BP) begin : g_bp
         assign bp_gated = structured & bp_tick;
      end else begin : g_no_bp
         assign bp_gated = 1'b0;
      end
   endgenerate

   always_comb begin
      case (src_e'(src_sel))
         SRC_LINE: svc_tick = line_tick;
         SRC_PLL:  svc_tick = pll_tick;
         SRC_BP:   svc_tick = bp_gated;
         default:  svc_tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/srts_period_div.sv
module srts_period_div #(
   parameter int DIV_MAIN = 3008,
   parameter int DIV_ALT  = 3000
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic use_alt,
   output logic term
);
   localparam int DIV_MAX = (DIV_MAIN > DIV_ALT) ? DIV_MAIN : DIV_ALT;
   localparam int CW      = $clog2(DIV_MAX + 1);

   generate
      if (DIV_MAIN < 2 || DIV_ALT < 2) begin : g_bad_ratio
         $error("srts_period_div: divide ratios must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = use_alt ? CW'(DIV_ALT - 1) : CW'(DIV_MAIN - 1);
   assign term = tick && (cnt >= last);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (term) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2: the count never reaches the larger ratio
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
      cnt < CW'(DIV_MAX));
   // R2: a terminal tick restarts the period
   p_term_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      term |=> (cnt == '0));
   // R2: without a tick the count holds
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/srts_nib_fifo.sv
module srts_nib_fifo #(
   parameter int W     = 4,
   parameter int DEPTH = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] wr_data,
   input  logic         pop,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty,
   output logic         ovf_ev,
   output logic         unf_ev
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || W < 1) begin : g_bad_cfg
         $error("srts_nib_fifo: DEPTH must be >= 2 and W >= 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign ovf_ev  = push && !do_push;
   assign unf_ev  = pop && empty;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (do_push && (wptr == AW'(i))) begin
               mem[i] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         rd_data <= '0;
      end else begin
         if (do_push) begin
            wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         end
         if (do_pop) begin
            rd_data <= mem[rptr];
            rptr    <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         end
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R6: occupancy bounded by the depth
   p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));
   // R7: a dropped write leaves the queue full
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      (push && full && !pop) |=> full);
   // R8: a pop on empty leaves the output nibble unchanged
   p_unf_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (pop && empty) |=> $stable(rd_data));
endmodule

// File: rtl/srts_sticky.sv
module srts_sticky (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end else if (clr) begin
         q <= 1'b0;
      end
   end

   // R9: an event always wins over a clear
   p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      set |=> q);
   // R9: a clear without an event drops the flag
   p_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (clr && !set) |=> !q);
endmodule

// File: rtl/srts_gen.sv
module srts_gen #(
   parameter int NIB_W      = 4,
   parameter int FIFO_DEPTH = 5,
   parameter int DIV_MAIN   = 3008,
   parameter int DIV_ALT    = 3000,
   parameter bit ALLOW_BP   = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       src_sel,
   input  logic             structured,
   input  logic             line_tick,
   input  logic             pll_tick,
   input  logic             bp_tick,
   input  logic             div_alt,
   input  logic             cnt_sel,
   input  logic [NIB_W-1:0] net_cnt_a,
   input  logic [NIB_W-1:0] net_cnt_b,
   input  logic             ts_pop,
   output logic [NIB_W-1:0] ts_nibble,
   input  logic             clr_ovf,
   input  logic             clr_unf,
   output logic             ovf_flag,
   output logic             unf_flag
);
   import srts_pkg::*;

   logic             svc_tick;
   logic             period_end;
   logic [NIB_W-1:0] sample;
   logic             q_full, q_empty;
   logic             ovf_ev, unf_ev;

   srts_clk_sel #(.ALLOW_BP(ALLOW_BP)) u_sel (
      .src_sel    (src_sel),
      .structured (structured),
      .line_tick  (line_tick),
      .pll_tick   (pll_tick),
      .bp_tick    (bp_tick),
      .svc_tick   (svc_tick)
   );

   srts_period_div #(.DIV_MAIN(DIV_MAIN), .DIV_ALT(DIV_ALT)) u_div (
      .clk     (clk),
      .rst     (rst),
      .tick    (svc_tick),
      .use_alt (div_alt),
      .term    (period_end)
   );

   assign sample = cnt_sel ? net_cnt_b : net_cnt_a;

   srts_nib_fifo #(.W(NIB_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .push    (period_end),
      .wr_data (sample),
      .pop     (ts_pop),
      .rd_data (ts_nibble),
      .full    (q_full),
      .empty   (q_empty),
      .ovf_ev  (ovf_ev),
      .unf_ev  (unf_ev)
   );

   srts_sticky u_ovf (
      .clk (clk), .rst (rst), .set (ovf_ev), .clr (clr_ovf), .q (ovf_flag)
   );

   srts_sticky u_unf (
      .clk (clk), .rst (rst), .set (unf_ev), .clr (clr_unf), .q (unf_flag)
   );

   // R5: backplane strobes never count outside structured mode
   p_bp_blocked_r5: assert property (@(posedge clk) disable iff (rst)
      (!structured && src_sel == SRC_BP) |-> !svc_tick);
   // R5: source code 3 counts nothing
   p_src_none_r5: assert property (@(posedge clk) disable iff (rst)
      (src_sel == SRC_NONE) |-> !period_end);
   // R7: overflow flag is sticky until cleared
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag && !clr_ovf) |=> ovf_flag);
   // R8: pop on an empty queue raises the underrun flag
   p_unf_set_r8: assert property (@(posedge clk) disable iff (rst)
      (ts_pop && q_empty) |=> unf_flag);
   // R8: underrun flag is sticky until cleared
   p_unf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (unf_flag && !clr_unf) |=> unf_flag);
endmodule

// File: tb/srts_gen_tb.sv
module srts_gen_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic [1:0] src_sel;
   logic       structured, line_tick, pll_tick, bp_tick;
   logic       div_alt, cnt_sel;
   logic [3:0] net_cnt_a, net_cnt_b;
   logic       ts_pop, clr_ovf, clr_unf;
   logic [3:0] ts_nibble;
   logic       ovf_flag, unf_flag;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [3:0] exp_q[$];

   always #5 clk = ~clk;

   srts_gen u_dut (
      .clk (clk), .rst (rst), .src_sel (src_sel), .structured (structured),
      .line_tick (line_tick), .pll_tick (pll_tick), .bp_tick (bp_tick),
      .div_alt (div_alt), .cnt_sel (cnt_sel),
      .net_cnt_a (net_cnt_a), .net_cnt_b (net_cnt_b),
      .ts_pop (ts_pop), .ts_nibble (ts_nibble),
      .clr_ovf (clr_ovf), .clr_unf (clr_unf),
      .ovf_flag (ovf_flag), .unf_flag (unf_flag)
   );

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive n strobes, one per cycle, on the lines chosen by m = {bp,pll,line}
   task automatic ticks(int n, logic [2:0] m);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         {bp_tick, pll_tick, line_tick} = m;
      end
      @(negedge clk);
      {bp_tick, pll_tick, line_tick} = 3'b000;
   endtask

   // driver: a full period whose last tick sees v_last on the chosen counter
   task automatic period(int n, logic [2:0] m, logic sel, logic [3:0] v_pre,
                         logic [3:0] v_last, bit queued);
      cnt_sel = sel;
      if (sel) begin net_cnt_b = v_pre; net_cnt_a = ~v_last; end
      else     begin net_cnt_a = v_pre; net_cnt_b = ~v_last; end
      ticks(n - 1, m);
      if (sel) net_cnt_b = v_last; else net_cnt_a = v_last;
      ticks(1, m);
      if (queued) exp_q.push_back(v_last);
   endtask

   // monitor: pop one nibble and compare with the scoreboard head
   task automatic pop_check(string req);
      logic [3:0] e;
      @(negedge clk); ts_pop = 1'b1;
      @(negedge clk); ts_pop = 1'b0;
      e = exp_q.pop_front();
      check(req, ts_nibble, e);
   endtask

   task automatic pop_empty(string req, logic [3:0] hold);
      @(negedge clk); ts_pop = 1'b1;
      @(negedge clk); ts_pop = 1'b0;
      check({req, " underrun flag"}, unf_flag, 1);
      check({req, " nibble held"}, ts_nibble, hold);
   endtask

   task automatic clear(bit o, bit u);
      @(negedge clk); clr_ovf = o; clr_unf = u;
      @(negedge clk); clr_ovf = 1'b0; clr_unf = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; src_sel = 2'd0; structured = 1'b0;
      {bp_tick, pll_tick, line_tick} = 3'b000;
      div_alt = 1'b0; cnt_sel = 1'b0; net_cnt_a = '0; net_cnt_b = '0;
      ts_pop = 1'b0; clr_ovf = 1'b0; clr_unf = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check("R1 nibble", ts_nibble, 0);
      check("R1 ovf", ovf_flag, 0);
      check("R1 unf", unf_flag, 0);
      pop_empty("R1 empty after reset", 4'd0);
      clear(1'b0, 1'b1);
      check("R9 unf cleared", unf_flag, 0);

      // R2, R4, R10: 3008-tick period on line clock, counter A
      period(3008, 3'b001, 1'b0, 4'd3, 4'd9, 1'b1);
      pop_check("R2 R4 R10 div 3008 counter A");

      // R3, R4: 3000-tick period, counter B
      div_alt = 1'b1;
      period(3000, 3'b001, 1'b1, 4'd5, 4'hC, 1'b1);
      pop_check("R3 R4 div 3000 counter B");

      // R5: PLL selected, line strobes ignored
      src_sel = 2'd1;
      ticks(3000, 3'b001);
      pop_empty("R5 line ignored under PLL", 4'hC);
      clear(1'b0, 1'b1);
      period(3000, 3'b010, 1'b0, 4'd1, 4'd6, 1'b1);
      pop_check("R5 PLL source");

      // R5: backplane blocked in unstructured mode, counted in structured mode
      src_sel = 2'd2; structured = 1'b0;
      ticks(3000, 3'b100);
      pop_empty("R5 backplane blocked", 4'd6);
      clear(1'b0, 1'b1);
      check("R9 unf cleared again", unf_flag, 0);
      structured = 1'b1;
      period(3000, 3'b100, 1'b1, 4'd2, 4'd7, 1'b1);
      pop_check("R5 backplane structured");

      // R5: code 3 counts nothing
      src_sel = 2'd3;
      ticks(3000, 3'b111);
      pop_empty("R5 source none", 4'd7);
      clear(1'b0, 1'b1);

      // R6, R7: fill five, sixth dropped
      src_sel = 2'd0;
      for (int k = 1; k <= 5; k++) begin
         period(3000, 3'b001, 1'b0, 4'd0, 4'(k + 8), 1'b1);
      end
      check("R7 no ovf at five entries", ovf_flag, 0);
      period(3000, 3'b001, 1'b0, 4'd0, 4'd15, 1'b0);
      check("R7 ovf set on sixth", ovf_flag, 1);
      repeat (10) @(negedge clk);
      check("R7 ovf sticky", ovf_flag, 1);
      for (int k = 0; k < 5; k++) begin
         pop_check("R6 fifo order");
      end
      pop_empty("R8 underrun after drain", 4'd13);
      clear(1'b1, 1'b0);
      check("R9 ovf cleared", ovf_flag, 0);
      check("R9 unf kept while ovf cleared", unf_flag, 1);
      clear(1'b0, 1'b1);
      check("R9 unf cleared final", unf_flag, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule